// File: doc/BRIEF.md
# Doorbell Command Mailbox Responder

This block is the peripheral side of a host-to-peripheral command channel built on a control block in shared memory. The host rings a doorbell by writing to one fixed I/O address. The responder then walks the control block through a simple memory master port. On the first command after reset it first fetches a 32-bit pointer from a fixed memory location. It then reads the device and command words, writes an "accepted" code into the result word, and hands the command to an external handler through a start/done handshake.

When the handler reports done, the responder stores the handler's status code in the result word and clears the pending flag (bit 15) of the command word. For every command except the first one after reset, it then raises a level interrupt towards the host. The first command is the power-up initialization request and is checked for a fixed device/command pair. A doorbell that arrives while a command is in progress is remembered and served once the responder is idle again.

Status codes used in the result word (low byte, upper byte zero): 00h no error, 01h general error, 02h device not supported, 03h device not present, 04h invalid command, 05h interrupt/DMA error, 06h controller command error, FFh accepted but not finished.

Top module: `mbox_responder`

## Requirements
- R1: Only an I/O write (`io_wr_en` high) to address 000Eh rings the doorbell; I/O writes to any other address cause no memory access and no interrupt.
- R2: On the first doorbell after reset the responder reads the 16-bit words at byte addresses 1FFFCh and then 1FFFEh and forms the control block pointer as {word at 1FFFEh, word at 1FFFCh}; later doorbells reuse the latched pointer without reading these locations again.
- R3: For each command the responder reads the device word at pointer+0, then the command word at pointer+2, then writes 00FFh to the result word at pointer+4, in that order and before any handler start.
- R4: For the first command after reset, a device word other than 12 or a command field (bits 14:0) other than 0 makes the responder write status 0004h without pulsing `hnd_start`.
- R5: An accepted command produces exactly one single-cycle `hnd_start` pulse with `hnd_dev` and `hnd_cmd` holding the words read. The responder waits for `hnd_done`, and `hnd_done` is ignored at any other time.
- R6: On completion the responder writes {8'h00, status} to pointer+4, then writes the command word as read with bit 15 cleared to pointer+2.
- R7: For every command except the first after reset, `irq` rises in the second cycle after the clear-pending write is acknowledged. `irq` never rises after the first command.
- R8: `irq` stays high until a cycle with `irq_ack` high clears it. If `irq_ack` is high in the cycle a new interrupt is raised, the interrupt still goes high for one cycle.
- R9: Doorbells rung while a command is in progress are collapsed into one pending request that is served after the return to idle. A doorbell in the same cycle that a pending request is taken stays pending.
- R10: The memory master makes one access at a time and holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stable until `mem_ack`.
- R11: After reset, `mem_req`, `hnd_start` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr_en | input | 1 | Host I/O write strobe |
| io_wr_addr | input | IO_W (16) | Host I/O write address |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W (32) | Byte address of the 16-bit word |
| mem_wdata | output | DATA_W (16) | Write data |
| mem_ack | input | 1 | Access completes; read data valid in this cycle |
| mem_rdata | input | DATA_W (16) | Read data |
| hnd_start | output | 1 | One-cycle handler start pulse |
| hnd_dev | output | DATA_W (16) | Device word of the current command |
| hnd_cmd | output | DATA_W (16) | Command word of the current command |
| hnd_done | input | 1 | Handler completion strobe |
| hnd_status | input | STAT_W (8) | Handler status code, valid with `hnd_done` |
| irq | output | 1 | Level interrupt to the host |
| irq_ack | input | 1 | Host clears the interrupt |

## Verification
Two pairs of events can fall in the same cycle. A new doorbell can coincide with the cycle in which the idle sequencer takes the pending one. An interrupt acknowledge can coincide with the cycle in which a new interrupt is raised. The first pair is provoked by holding the I/O write to 000Eh for two consecutive cycles. It is judged by seeing two complete command sequences in the memory access stream. The second pair is provoked by holding `irq_ack` high through a whole command. It is judged by seeing `irq` high for one cycle and then low again.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PLO,
    S_PHI,
    S_DEV,
    S_CMD,
    S_ACK,
    S_START,
    S_WAIT,
    S_STAT,
    S_CLR
  } seq_state_t;

  localparam logic [7:0] ST_OK        = 8'h00;
  localparam logic [7:0] ST_GENERAL   = 8'h01;
  localparam logic [7:0] ST_NO_DEVSUP = 8'h02;
  localparam logic [7:0] ST_NO_DEV    = 8'h03;
  localparam logic [7:0] ST_BAD_CMD   = 8'h04;
  localparam logic [7:0] ST_IRQ_DMA   = 8'h05;
  localparam logic [7:0] ST_CTRL      = 8'h06;
  localparam logic [7:0] ST_ACCEPTED  = 8'hFF;

endpackage

// File: rtl/mbox_doorbell.sv
module mbox_doorbell #(
  parameter int unsigned IO_W    = 16,
  parameter int unsigned DB_ADDR = 16'h000E
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            io_wr_en,
  input  logic [IO_W-1:0] io_wr_addr,
  input  logic            take,
  output logic            pending
);

  logic ring;

  assign ring = io_wr_en && (io_wr_addr == IO_W'(DB_ADDR));

  // a ring in the same cycle as a take keeps the request pending
  always_ff @(posedge clk) begin
    if (rst) pending <= 1'b0;
    else     pending <= ring || (pending && !take);
  end

endmodule

// File: rtl/mbox_bus_port.sv
module mbox_bus_port #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_we,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (mem_req) begin
        if (mem_ack) begin
          mem_req   <= 1'b0;
          rsp_valid <= 1'b1;
          rsp_rdata <= mem_rdata;
        end
      end else if (cmd_valid) begin
        mem_req   <= 1'b1;
        mem_we    <= cmd_we;
        mem_addr  <= cmd_addr;
        mem_wdata <= cmd_wdata;
      end
    end
  end

endmodule

// File: rtl/mbox_irq.sv
module mbox_irq (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic ack,
  output logic irq
);

  // raising wins over a coincident acknowledge
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= set || (irq && !ack);
  end

endmodule

// File: rtl/mbox_seq.sv
module mbox_seq
  import mbox_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned STAT_W   = 8,
  parameter int unsigned PTR_LOC  = 32'h0001_FFFC,
  parameter int unsigned DEV_OFS  = 0,
  parameter int unsigned CMD_OFS  = 2,
  parameter int unsigned RES_OFS  = 4,
  parameter int unsigned INIT_DEV = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              db_pend,
  output logic              db_take,
  output logic              bus_valid,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_rdata,
  output logic              hnd_start,
  output logic [DATA_W-1:0] hnd_dev,
  output logic [DATA_W-1:0] hnd_cmd,
  input  logic              hnd_done,
  input  logic [STAT_W-1:0] hnd_status,
  output logic              irq_set
);

  localparam int unsigned PEND_BIT = DATA_W - 1;
  localparam int unsigned PAD_W    = DATA_W - STAT_W;
  localparam int unsigned BYTE_STEP = DATA_W / 8;

  seq_state_t        state_q;
  logic              issued_q;
  logic              ptr_ok_q;
  logic              first_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [DATA_W-1:0] dev_q;
  logic [DATA_W-1:0] cmd_q;
  logic [STAT_W-1:0] status_q;
  logic              acc_state;
  logic              init_ok;

  assign hnd_dev = dev_q;
  assign hnd_cmd = cmd_q;
  assign init_ok = (dev_q == DATA_W'(INIT_DEV)) && (cmd_q[PEND_BIT-1:0] == '0);
  assign db_take = (state_q == S_IDLE) && db_pend;
  assign irq_set = (state_q == S_CLR) && rsp_valid && !first_q;

  always_comb begin
    acc_state = 1'b1;
    bus_we    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    case (state_q)
      S_PLO:   bus_addr = ADDR_W'(PTR_LOC);
      S_PHI:   bus_addr = ADDR_W'(PTR_LOC + BYTE_STEP);
      S_DEV:   bus_addr = ptr_q + ADDR_W'(DEV_OFS);
      S_CMD:   bus_addr = ptr_q + ADDR_W'(CMD_OFS);
      S_ACK: begin
        bus_we    = 1'b1;
        bus_addr  = ptr_q + ADDR_W'(RES_OFS);
        bus_wdata = DATA_W'(ST_ACCEPTED);
      end
      S_STAT: begin
        bus_we    = 1'b1;
        bus_addr  = ptr_q + ADDR_W'(RES_OFS);
        bus_wdata = {{PAD_W{1'b0}}, status_q};
      end
      S_CLR: begin
        bus_we    = 1'b1;
        bus_addr  = ptr_q + ADDR_W'(CMD_OFS);
        bus_wdata = cmd_q & ~(DATA_W'(1) << PEND_BIT);
      end
      default: acc_state = 1'b0;
    endcase
  end

  assign bus_valid = acc_state && !issued_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      issued_q  <= 1'b0;
      ptr_ok_q  <= 1'b0;
      first_q   <= 1'b1;
      ptr_q     <= '0;
      dev_q     <= '0;
      cmd_q     <= '0;
      status_q  <= '0;
      hnd_start <= 1'b0;
    end else begin
      hnd_start <= 1'b0;
      if (bus_valid) issued_q <= 1'b1;
      if (rsp_valid) issued_q <= 1'b0;
      case (state_q)
        S_IDLE: if (db_pend) state_q <= ptr_ok_q ? S_DEV : S_PLO;
        S_PLO: if (rsp_valid) begin
          ptr_q   <= ADDR_W'(rsp_rdata);
          state_q <= S_PHI;
        end
        S_PHI: if (rsp_valid) begin
          ptr_q    <= ADDR_W'({rsp_rdata, ptr_q[DATA_W-1:0]});
          ptr_ok_q <= 1'b1;
          state_q  <= S_DEV;
        end
        S_DEV: if (rsp_valid) begin
          dev_q   <= rsp_rdata;
          state_q <= S_CMD;
        end
        S_CMD: if (rsp_valid) begin
          cmd_q   <= rsp_rdata;
          state_q <= S_ACK;
        end
        S_ACK: if (rsp_valid) begin
          if (first_q && !init_ok) begin
            status_q <= STAT_W'(ST_BAD_CMD);
            state_q  <= S_STAT;
          end else begin
            state_q <= S_START;
          end
        end
        S_START: begin
          hnd_start <= 1'b1;
          state_q   <= S_WAIT;
        end
        S_WAIT: if (hnd_done) begin
          status_q <= hnd_status;
          state_q  <= S_STAT;
        end
        S_STAT: if (rsp_valid) state_q <= S_CLR;
        S_CLR: if (rsp_valid) begin
          first_q <= 1'b0;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mbox_responder.sv
module mbox_responder #(
  parameter int unsigned IO_W     = 16,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned STAT_W   = 8,
  parameter int unsigned DB_ADDR  = 16'h000E,
  parameter int unsigned PTR_LOC  = 32'h0001_FFFC,
  parameter int unsigned INIT_DEV = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_wr_en,
  input  logic [IO_W-1:0]   io_wr_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              hnd_start,
  output logic [DATA_W-1:0] hnd_dev,
  output logic [DATA_W-1:0] hnd_cmd,
  input  logic              hnd_done,
  input  logic [STAT_W-1:0] hnd_status,
  output logic              irq,
  input  logic              irq_ack
);

  logic              db_pend;
  logic              db_take;
  logic              bus_valid;
  logic              bus_we;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic              rsp_valid;
  logic [DATA_W-1:0] rsp_rdata;
  logic              irq_set;

  mbox_doorbell #(.IO_W(IO_W), .DB_ADDR(DB_ADDR)) u_db (
    .clk(clk), .rst(rst), .io_wr_en(io_wr_en), .io_wr_addr(io_wr_addr),
    .take(db_take), .pending(db_pend)
  );

  mbox_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_W(STAT_W),
    .PTR_LOC(PTR_LOC), .DEV_OFS(0), .CMD_OFS(2), .RES_OFS(4), .INIT_DEV(INIT_DEV)
  ) u_seq (
    .clk(clk), .rst(rst), .db_pend(db_pend), .db_take(db_take),
    .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .hnd_start(hnd_start), .hnd_dev(hnd_dev), .hnd_cmd(hnd_cmd),
    .hnd_done(hnd_done), .hnd_status(hnd_status), .irq_set(irq_set)
  );

  mbox_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst(rst),
    .cmd_valid(bus_valid), .cmd_we(bus_we), .cmd_addr(bus_addr), .cmd_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  mbox_irq u_irq (
    .clk(clk), .rst(rst), .set(irq_set), .ack(irq_ack), .irq(irq)
  );

endmodule

// File: rtl/mbox_responder_chk.sv
module mbox_responder_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack,
  input logic              hnd_start,
  input logic              irq,
  input logic              irq_ack,
  input logic              irq_set
);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

  p_start_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    hnd_start |=> !hnd_start);

  p_start_no_bus_r5: assert property (@(posedge clk) disable iff (rst)
    hnd_start |-> !mem_req);

  p_irq_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_ack) |=> irq);

  p_irq_ack_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !irq_set) |=> !irq);

  p_irq_after_write_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(mem_req && mem_ack && mem_we, 2));

endmodule

bind mbox_responder mbox_responder_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack), .hnd_start(hnd_start), .irq(irq),
  .irq_ack(irq_ack), .irq_set(irq_set)
);

// File: tb/mbox_responder_tb_top.sv
`timescale 1ns/1ps
module mbox_responder_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_wr_en = 1'b0;
  logic [15:0] io_wr_addr = '0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        hnd_start;
  logic [15:0] hnd_dev, hnd_cmd;
  logic        hnd_done;
  logic        h_done = 1'b0;
  logic        poke_done = 1'b0;
  logic [7:0]  hnd_status = '0;
  logic        irq;
  logic        irq_ack = 1'b0;

  assign hnd_done = h_done | poke_done;

  always #2 clk = ~clk;

  mbox_responder dut_i (
    .clk(clk), .rst(rst), .io_wr_en(io_wr_en), .io_wr_addr(io_wr_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .hnd_start(hnd_start), .hnd_dev(hnd_dev), .hnd_cmd(hnd_cmd),
    .hnd_done(hnd_done), .hnd_status(hnd_status), .irq(irq), .irq_ack(irq_ack)
  );

  localparam logic [31:0] P = 32'h0003_1A40;

  int nchk = 0;
  int nfail = 0;
  int nacc = 0;
  int starts = 0;
  int cyc = 0;

  logic [15:0] m [logic [31:0]];
  bit          e_we [$];
  logic [31:0] e_addr [$];
  logic [15:0] e_data [$];
  string       e_tag [$];
  bit          e_irq [$];
  logic [15:0] x_dev [$];
  logic [15:0] x_cmd [$];
  logic [7:0]  x_st [$];
  bit          irq_ok = 1'b0;
  bit          irq_seen = 1'b0;
  bit          h_pend = 1'b0;
  int          hcnt = 0;
  int          h_delay = 3;
  logic [7:0]  h_st = '0;

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(bit we, logic [31:0] a, logic [15:0] d, string tag, bit irqf);
    e_we.push_back(we); e_addr.push_back(a); e_data.push_back(d);
    e_tag.push_back(tag); e_irq.push_back(irqf);
  endtask

  task automatic expect_cmd(bit fetch, bit first, logic [15:0] dev, logic [15:0] cmd,
                            logic [7:0] st, bit run);
    if (fetch) begin
      push(1'b0, 32'h0001_FFFC, 16'h0, "R2", 1'b0);
      push(1'b0, 32'h0001_FFFE, 16'h0, "R2", 1'b0);
    end
    push(1'b0, P + 0, 16'h0, "R3", 1'b0);
    push(1'b0, P + 2, 16'h0, "R3", 1'b0);
    push(1'b1, P + 4, 16'h00FF, "R3", 1'b0);
    if (run) begin
      x_dev.push_back(dev); x_cmd.push_back(cmd); x_st.push_back(st);
    end
    push(1'b1, P + 4, {8'h00, st}, "R6", 1'b0);
    push(1'b1, P + 2, cmd & 16'h7FFF, "R6", !first);
  endtask

  // memory slave: variable latency, checks every access against the model
  int w = 0;
  int lat = 0;
  always @(negedge clk) begin
    mem_ack = 1'b0;
    if (rst) begin
      w = 0;
    end else if (mem_req) begin
      if (w >= lat) begin
        w = 0;
        nacc++;
        lat = nacc % 3;
        mem_ack = 1'b1;
        if (e_we.size() == 0) begin
          check(1'b0, "R10", "unexpected memory access addr", mem_addr, 0);
        end else begin
          automatic bit          xw = e_we.pop_front();
          automatic logic [31:0] xa = e_addr.pop_front();
          automatic logic [15:0] xd = e_data.pop_front();
          automatic string       xt = e_tag.pop_front();
          automatic bit          xi = e_irq.pop_front();
          check(mem_we == xw && mem_addr == xa, xt, "access kind/address",
                {mem_we, mem_addr}, {xw, xa});
          if (xw) check(mem_wdata == xd, xt, "write data", mem_wdata, xd);
          if (xi) irq_ok = 1'b1;
        end
        if (mem_we) m[mem_addr] = mem_wdata;
        else mem_rdata = m.exists(mem_addr) ? m[mem_addr] : 16'h0;
      end else begin
        w++;
      end
    end
  end

  // handler model
  always @(negedge clk) begin
    h_done = 1'b0;
    if (rst) begin
      h_pend = 1'b0;
    end else if (hnd_start) begin
      starts++;
      if (x_dev.size() == 0) begin
        check(1'b0, "R5", "unexpected handler start", 1, 0);
      end else begin
        automatic logic [15:0] d = x_dev.pop_front();
        automatic logic [15:0] c = x_cmd.pop_front();
        h_st = x_st.pop_front();
        check(hnd_dev == d, "R5", "hnd_dev", hnd_dev, d);
        check(hnd_cmd == c, "R5", "hnd_cmd", hnd_cmd, c);
      end
      h_pend = 1'b1;
      hcnt = h_delay;
    end else if (h_pend) begin
      if (hcnt == 0) begin
        h_done = 1'b1;
        hnd_status = h_st;
        h_pend = 1'b0;
      end else begin
        hcnt--;
      end
    end
  end

  // per-cycle interrupt model
  always @(negedge clk) begin
    if (!rst) begin
      check(!irq || irq_ok, "R7", "irq raised without a finished non-first command", irq, 0);
      if (irq) irq_seen = 1'b1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      check(1'b0, "R10", "watchdog expired", cyc, 0);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  task automatic ring(logic [15:0] a, int n);
    @(negedge clk);
    io_wr_en = 1'b1; io_wr_addr = a;
    repeat (n) @(negedge clk);
    io_wr_en = 1'b0;
  endtask

  task automatic wait_done();
    while (e_we.size() != 0 || h_pend) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    irq_ok = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic ack_irq();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0; irq_ok = 1'b0;
    check(irq == 1'b0, "R8", "irq after acknowledge", irq, 0);
  endtask

  initial begin
    automatic int a0;
    automatic int s0;
    m[32'h0001_FFFC] = 16'h1A40;
    m[32'h0001_FFFE] = 16'h0003;
    do_reset();
    check(mem_req == 1'b0 && hnd_start == 1'b0 && irq == 1'b0, "R11", "outputs after reset",
          {mem_req, hnd_start, irq}, 0);

    // R1: writes to another I/O address do nothing
    a0 = nacc;
    ring(16'h000C, 1);
    ring(16'h000F, 1);
    repeat (20) @(negedge clk);
    check(nacc == a0, "R1", "accesses after non-doorbell writes", nacc - a0, 0);
    check(irq == 1'b0, "R1", "irq after non-doorbell writes", irq, 0);

    // first command: power-up init, pointer fetched, no interrupt
    m[P] = 16'd12; m[P + 2] = 16'h8000; m[P + 4] = 16'h0;
    expect_cmd(1'b1, 1'b1, 16'd12, 16'h8000, 8'h00, 1'b1);
    ring(16'h000E, 1);
    wait_done();
    check(e_we.size() == 0, "R3", "pending accesses after first command", e_we.size(), 0);
    check(starts == 1, "R5", "handler starts", starts, 1);
    check(m[P + 2] == 16'h0000, "R6", "command word after first command", m[P + 2], 0);
    check(irq == 1'b0, "R7", "irq after first command", irq, 0);

    // second command: no pointer refetch, status 2, interrupt held
    m[P] = 16'd3; m[P + 2] = 16'h8005;
    expect_cmd(1'b0, 1'b0, 16'd3, 16'h8005, 8'h02, 1'b1);
    ring(16'h000E, 1);
    wait_done();
    check(irq == 1'b1, "R7", "irq after second command", irq, 1);
    check(m[P + 4] == 16'h0002, "R6", "result word", m[P + 4], 16'h0002);
    check(m[P + 2] == 16'h0005, "R6", "command word", m[P + 2], 16'h0005);
    repeat (10) @(negedge clk);
    check(irq == 1'b1, "R8", "irq held without acknowledge", irq, 1);
    ack_irq();

    // R9: two doorbells during execution collapse into one extra command
    h_delay = 12;
    m[P] = 16'd7; m[P + 2] = 16'h8011;
    s0 = starts;
    expect_cmd(1'b0, 1'b0, 16'd7, 16'h8011, 8'h06, 1'b1);
    expect_cmd(1'b0, 1'b0, 16'd7, 16'h0011, 8'h06, 1'b1);
    ring(16'h000E, 1);
    while (starts == s0) @(negedge clk);
    ring(16'h000E, 1);
    repeat (2) @(negedge clk);
    ring(16'h000E, 1);
    wait_done();
    repeat (20) @(negedge clk);
    check(starts == s0 + 2, "R9", "commands served for collapsed doorbells", starts - s0, 2);
    check(e_we.size() == 0, "R9", "pending accesses", e_we.size(), 0);
    ack_irq();

    // R9: doorbell in the same cycle as the take stays pending
    h_delay = 2;
    m[P] = 16'd5; m[P + 2] = 16'h8021;
    s0 = starts;
    expect_cmd(1'b0, 1'b0, 16'd5, 16'h8021, 8'h01, 1'b1);
    expect_cmd(1'b0, 1'b0, 16'd5, 16'h0021, 8'h01, 1'b1);
    ring(16'h000E, 2);
    wait_done();
    repeat (20) @(negedge clk);
    check(starts == s0 + 2, "R9", "commands for ring coinciding with take", starts - s0, 2);
    ack_irq();

    // R8: acknowledge held while the interrupt is raised
    irq_seen = 1'b0;
    m[P + 2] = 16'h8030;
    expect_cmd(1'b0, 1'b0, 16'd5, 16'h8030, 8'hFF, 1'b1);
    @(negedge clk); irq_ack = 1'b1;
    ring(16'h000E, 1);
    wait_done();
    check(irq_seen == 1'b1, "R8", "irq pulse with acknowledge held", irq_seen, 1);
    check(irq == 1'b0, "R8", "irq cleared by held acknowledge", irq, 0);
    irq_ack = 1'b0; irq_ok = 1'b0;

    // R5: stray handler done while idle is ignored
    a0 = nacc;
    @(negedge clk); poke_done = 1'b1;
    @(negedge clk); poke_done = 1'b0;
    repeat (15) @(negedge clk);
    check(nacc == a0, "R5", "accesses after stray done", nacc - a0, 0);
    check(irq == 1'b0, "R5", "irq after stray done", irq, 0);

    // R4: after reset, a wrong first command gets status 4 and no handler run
    do_reset();
    check(irq == 1'b0 && mem_req == 1'b0, "R11", "outputs after second reset",
          {irq, mem_req}, 0);
    m[P] = 16'd12; m[P + 2] = 16'h8003;
    s0 = starts;
    expect_cmd(1'b1, 1'b1, 16'd12, 16'h8003, 8'h04, 1'b0);
    ring(16'h000E, 1);
    wait_done();
    check(starts == s0, "R4", "handler starts for rejected first command", starts - s0, 0);
    check(m[P + 4] == 16'h0004, "R4", "result word", m[P + 4], 16'h0004);
    check(m[P + 2] == 16'h0003, "R6", "command word", m[P + 2], 16'h0003);
    check(irq == 1'b0, "R7", "irq after rejected first command", irq, 0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule